// File: doc/BRIEF.md
# Atomic Bit Test-and-Modify Unit

This execution unit carries out an indivisible read-modify-write on a single bit of a byte-wide, bit-addressable memory. Software builds locks and semaphores on it. The unit takes two operations:

- **Test-and-set** makes the target bit 1.
- **Test-and-clear** makes the target bit 0.

Each operation arrives as an already-decoded opcode together with a 16-bit bit address. The unit returns the value the bit held before the change as the carry flag.

For each operation the unit runs a fixed sequence:

1. It requests the memory port and waits for a grant.
2. It raises a lock that keeps every other requester off the port.
3. It reads the byte that contains the target bit.
4. It merges the new bit value into that byte.
5. It writes the whole byte back.
6. It pulses a one-cycle done signal with the old bit value on the carry output.

Because the lock stays up from the grant to the end of the write-back, no other master can observe or change the byte partway through the operation. The write-back always happens, even when the bit already holds the requested value. The cycle count therefore depends only on how long the grant takes.

The memory is synchronous. Read data appears on `mem_rdata` in the cycle after the cycle in which `mem_re` is high. A write takes effect at the clock edge that ends the cycle in which `mem_we` is high.

Top module: `atb_unit`

## Requirements
- R1: An operation is accepted only at a clock edge where `op_valid` is high, `op_ready` is high and `op_code` is 0x41 (test-and-set) or 0x61 (test-and-clear). Any other code is ignored: `mem_req` stays low, `op_ready` stays high and `carry` is unchanged.
- R2: The byte address driven on `mem_addr` is `op_bit_addr[15:3]`, and `op_bit_addr[2:0]` picks the bit inside that byte, with 0 as the least significant bit.
- R3: Test-and-set writes back the read byte with the selected bit forced to 1 and all other bits unchanged.
- R4: Test-and-clear writes back the read byte with the selected bit forced to 0 and all other bits unchanged.
- R5: In the cycle where `done` is high, `carry` equals the value the selected bit had in memory before the operation.
- R6: `carry` changes only in a cycle where `done` is high and otherwise holds its last value.
- R7: `mem_req` rises in the cycle after acceptance and stays high through the write cycle. No read is issued before `mem_gnt` has been seen high.
- R8: `mem_lock` is high in the grant cycle and stays high without a gap through the write cycle. Every read and write is issued while `mem_lock` is high.
- R9: Each operation performs exactly one read followed by exactly one write. The write happens even when the bit already held the requested value.
- R10: If the grant arrives in cycle g, the read is in g+1, the write in g+3 and `done` in g+4. With a grant in the first request cycle, `done` is high in the fifth cycle after the accepting edge.
- R11: `done` is a single-cycle pulse. `op_ready` is low from the accepting edge until the cycle after `done`, and operations offered while it is low are ignored.
- R12: After a synchronous active-high reset, `op_ready` is high and `mem_req`, `mem_lock`, `mem_re`, `mem_we`, `done` and `carry` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered |
| op_code | input | 8 | Decoded opcode: 0x41 set, 0x61 clear |
| op_bit_addr | input | 16 | Bit address of the operand |
| op_ready | output | 1 | Unit idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Carry flag: previous bit value |
| mem_req | output | 1 | Memory port request |
| mem_gnt | input | 1 | Memory port grant |
| mem_lock | output | 1 | Holds the port for this unit |
| mem_addr | output | 13 | Byte address |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |

## Verification
The vector table pairs each operation with starting bytes in which the target bit is already at the requested value and with bytes in which it is not. Matching the carry against the whole written byte separates a wrong bit select from a wrong merge, and shows whether the unit damaged neighbouring bits. Bit addresses at the lowest and highest bytes and at both bit ends of a byte confirm the address split. Directed runs with a delayed grant, an unsupported opcode and an operation offered while busy show that the timing depends only on the grant, and that stray requests leave memory and carry untouched.

// File: rtl/atb_pkg.sv
package atb_pkg;

    localparam int BIT_ADDR_W = 16;
    localparam int BYTE_W     = 8;

    localparam logic [7:0] OPC_TSET = 8'h41;
    localparam logic [7:0] OPC_TCLR = 8'h61;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOCK   = 3'd1,
        ST_READ   = 3'd2,
        ST_MODIFY = 3'd3,
        ST_WRITE  = 3'd4,
        ST_DONE   = 3'd5
    } atb_state_e;

    typedef struct packed {
        logic legal;
        logic set_bit;
    } atb_dec_t;

    function automatic atb_dec_t atb_decode(input logic [7:0] code);
        atb_dec_t d;
        d.legal   = (code == OPC_TSET) || (code == OPC_TCLR);
        d.set_bit = (code == OPC_TSET);
        return d;
    endfunction

endpackage

// File: rtl/atb_fsm.sv
module atb_fsm
    import atb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mem_gnt,
    output atb_state_e state,
    output logic       mem_req,
    output logic       mem_lock,
    output logic       mem_re,
    output logic       mem_we,
    output logic       done,
    output logic       ready
);

    atb_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)   nxt = ST_LOCK;
            ST_LOCK:   if (mem_gnt) nxt = ST_READ;
            ST_READ:   nxt = ST_MODIFY;
            ST_MODIFY: nxt = ST_WRITE;
            ST_WRITE:  nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        mem_req  = (state == ST_LOCK) || (state == ST_READ) ||
                   (state == ST_MODIFY) || (state == ST_WRITE);
        mem_lock = ((state == ST_LOCK) && mem_gnt) || (state == ST_READ) ||
                   (state == ST_MODIFY) || (state == ST_WRITE);
        mem_re   = (state == ST_READ);
        mem_we   = (state == ST_WRITE);
        done     = (state == ST_DONE);
        ready    = (state == ST_IDLE);
    end

    // R8: every access goes out under the lock
    assert_access_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_re || mem_we) |-> mem_lock);

    // R8: once raised, the lock stays up until the write cycle
    assert_lock_held_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_lock && !mem_we) |=> mem_lock);

    // R9: a write is always preceded by its read two cycles earlier
    assert_write_after_read_R9: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> ##1 mem_we);

    // R11: done lasts a single cycle
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: an idle unit does not request the port
    assert_idle_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> !mem_req);

    // R10: done follows the write by exactly one cycle
    assert_done_after_write_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> done);

endmodule

// File: rtl/atb_bitmerge.sv
module atb_bitmerge #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              set_bit,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] new_byte,
    output logic              old_bit
);

    logic [DATA_W-1:0] merged;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        always_comb begin
            merged[i] = (bit_sel == SEL_W'(i)) ? set_bit : rdata[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_byte <= '0;
            old_bit  <= 1'b0;
        end else if (capture) begin
            new_byte <= merged;
            old_bit  <= rdata[bit_sel];
        end
    end

    // R3/R4: the target bit of the byte to write carries the requested value
    assert_target_bit_R3: assert property (@(posedge clk) disable iff (rst)
        capture |=> (new_byte[$past(bit_sel)] == $past(set_bit)));

endmodule

// File: rtl/atb_unit.sv
module atb_unit
    import atb_pkg::*;
#(
    parameter int ADDR_W = BIT_ADDR_W,
    parameter int DATA_W = BYTE_W,
    localparam int SEL_W  = $clog2(DATA_W),
    localparam int BYTE_AW = ADDR_W - SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [7:0]         op_code,
    input  logic [ADDR_W-1:0]  op_bit_addr,
    output logic               op_ready,
    output logic               done,
    output logic               carry,
    output logic               mem_req,
    input  logic               mem_gnt,
    output logic               mem_lock,
    output logic [BYTE_AW-1:0] mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    atb_state_e        state;
    atb_dec_t          dec;
    logic              start;
    logic              cmd_set;
    logic [SEL_W-1:0]  cmd_sel;
    logic [BYTE_AW-1:0] cmd_byte;
    logic              old_bit;
    logic [DATA_W-1:0] new_byte;

    always_comb begin
        dec   = atb_decode(op_code);
        start = op_valid && dec.legal && (state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_set  <= 1'b0;
            cmd_sel  <= '0;
            cmd_byte <= '0;
        end else if (start) begin
            cmd_set  <= dec.set_bit;
            cmd_sel  <= op_bit_addr[SEL_W-1:0];
            cmd_byte <= op_bit_addr[ADDR_W-1:SEL_W];
        end
    end

    atb_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mem_gnt  (mem_gnt),
        .state    (state),
        .mem_req  (mem_req),
        .mem_lock (mem_lock),
        .mem_re   (mem_re),
        .mem_we   (mem_we),
        .done     (done),
        .ready    (op_ready)
    );

    atb_bitmerge #(.DATA_W(DATA_W)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .capture  (state == ST_MODIFY),
        .set_bit  (cmd_set),
        .bit_sel  (cmd_sel),
        .rdata    (mem_rdata),
        .new_byte (new_byte),
        .old_bit  (old_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)                    carry <= 1'b0;
        else if (state == ST_WRITE) carry <= old_bit;
    end

    assign mem_addr  = cmd_byte;
    assign mem_wdata = new_byte;

    // R6: the carry flag moves only with done
    assert_carry_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(carry));

    // R2: the byte address stays put while the port is locked
    assert_addr_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_lock && $past(mem_lock)) |-> $stable(mem_addr));

endmodule

// File: tb/tb_atb_unit.sv
module tb_atb_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [7:0]  op_code;
    logic [15:0] op_bit_addr;
    logic        op_ready, done, carry;
    logic        mem_req, mem_gnt, mem_lock, mem_re, mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    logic        gnt_en;
    logic        tb_wr;
    logic [12:0] tb_waddr;
    logic [7:0]  tb_wdata;
    logic [7:0]  mem [0:8191];
    int          re_cnt = 0, we_cnt = 0, bad_cnt = 0;
    int          checks = 0, errors = 0;
    int          cycles = 0;

    always #10 clk = ~clk;

    assign mem_gnt = mem_req && gnt_en;

    atb_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_bit_addr(op_bit_addr), .op_ready(op_ready), .done(done),
        .carry(carry), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        cycles++;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
        else if (tb_wr) mem[tb_waddr] <= tb_wdata;
        if (mem_re) re_cnt++;
        if (mem_we) we_cnt++;
        if ((mem_re || mem_we) && !mem_lock) bad_cnt++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        tb_wr = 1'b1; tb_waddr = a; tb_wdata = d;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    // issues an op and returns the number of negedges from acceptance to done
    task automatic run_op(input logic [7:0] code, input logic [15:0] ba,
                          input int gnt_delay, output int lat);
        @(negedge clk);
        gnt_en = (gnt_delay == 0);
        op_valid = 1'b1; op_code = code; op_bit_addr = ba;
        @(negedge clk);
        op_valid = 1'b0;
        lat = 1;
        for (int k = 0; k < gnt_delay; k++) begin
            chk("R7", "req while waiting", {31'd0, mem_req}, 32'd1);
            chk("R7", "no read before grant", {31'd0, mem_re}, 32'd0);
            @(negedge clk);
            lat++;
        end
        gnt_en = 1'b1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // {code, bit address, start byte, expected byte, expected carry}
    localparam int NV = 8;
    localparam logic [40:0] VEC [NV] = '{
        {8'h41, 16'h0000, 8'h00, 8'h01, 1'b0},
        {8'h41, 16'h0007, 8'h01, 8'h81, 1'b0},
        {8'h41, 16'h000B, 8'h08, 8'h08, 1'b1},
        {8'h61, 16'h000B, 8'h08, 8'h00, 1'b1},
        {8'h61, 16'h0012, 8'hFB, 8'hFB, 1'b0},
        {8'h61, 16'hFFFF, 8'hFF, 8'h7F, 1'b1},
        {8'h41, 16'hFFF8, 8'h5A, 8'h5B, 1'b0},
        {8'h61, 16'h1235, 8'hA5, 8'h85, 1'b1}
    };

    initial begin
        while (cycles < 100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat, r0, w0;
        logic [12:0] ba;
        rst = 1'b1; op_valid = 1'b0; op_code = 8'h00; op_bit_addr = '0;
        gnt_en = 1'b1; tb_wr = 1'b0; tb_waddr = '0; tb_wdata = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "op_ready", {31'd0, op_ready}, 32'd1);
        chk("R12", "req/lock/re/we/done/carry",
            {26'd0, mem_req, mem_lock, mem_re, mem_we, done, carry}, 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            ba = VEC[v][32:20];
            preload(ba, VEC[v][16:9]);
            r0 = re_cnt; w0 = we_cnt;
            run_op(VEC[v][40:33], VEC[v][32:17], 0, lat);
            chk("R5", "carry at done", {31'd0, carry}, {31'd0, VEC[v][0]});
            chk("R10", "latency", lat, 5);
            chk("R2", "byte address", {19'd0, mem_addr}, {19'd0, ba});
            @(negedge clk);
            chk(VEC[v][40:33] == 8'h41 ? "R3" : "R4", "written byte",
                {24'd0, mem[ba]}, {24'd0, VEC[v][8:1]});
            chk("R9", "reads/writes", (re_cnt - r0) * 16 + (we_cnt - w0), 17);
            chk("R11", "done pulse ended / ready back",
                {30'd0, done, op_ready}, 32'd1);
        end
        chk("R8", "unlocked accesses", bad_cnt, 0);

        // R1: unsupported opcode is ignored
        preload(13'h0040, 8'h3C);
        @(negedge clk);
        op_valid = 1'b1; op_code = 8'h51; op_bit_addr = 16'h0200;
        repeat (4) begin
            @(negedge clk);
            chk("R1", "no request on bad opcode", {31'd0, mem_req}, 32'd0);
        end
        op_valid = 1'b0;
        chk("R1", "ready stays high", {31'd0, op_ready}, 32'd1);
        chk("R1", "carry unchanged", {31'd0, carry}, 32'd1);
        chk("R1", "memory untouched", {24'd0, mem[13'h0040]}, 32'h3C);

        // R10/R7/R8: delayed grant, lock must not rise early
        preload(13'h0100, 8'h00);
        r0 = re_cnt;
        run_op(8'h41, 16'h0804, 3, lat);
        chk("R10", "latency with 3-cycle grant delay", lat, 8);
        chk("R5", "carry after delayed op", {31'd0, carry}, 32'd0);
        @(negedge clk);
        chk("R3", "byte after delayed op", {24'd0, mem[13'h0100]}, 32'h10);
        chk("R8", "unlocked accesses after delay", bad_cnt, 0);

        // R11: op offered while busy is ignored; R6 carry holds after done
        preload(13'h0101, 8'hFF);
        @(negedge clk);
        gnt_en = 1'b1;
        op_valid = 1'b1; op_code = 8'h61; op_bit_addr = 16'h0808;
        @(negedge clk);
        op_code = 8'h61; op_bit_addr = 16'h0809;
        chk("R11", "ready low while busy", {31'd0, op_ready}, 32'd0);
        repeat (5) @(negedge clk);
        op_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11", "busy offer ignored", {24'd0, mem[13'h0101]}, 32'hFE);
        chk("R6", "carry held after done", {31'd0, carry}, 32'd1);
        chk("R8", "unlocked accesses total", bad_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule